// File: doc/BRIEF.md
# Eight-Line Prioritised Interrupt Controller

This block collects eight level-sensitive interrupt request lines, resolves them by fixed priority and hands the winning line to a host processor as an 8-bit vector. The host reaches the block through a byte-wide register interface. A port-select bit chooses between a command port and a data port. Setup begins with an initialisation command on the command port. The block then takes three configuration bytes on the data port, in a fixed order: the vector base, then the cascade byte, then the mode byte. After that sequence, the data port reads and writes the per-line mask.

While any unmasked request outranks every line already in service, the interrupt output is high. An acknowledge pulse from the host then does three things:
- it moves the winning line into the in-service set;
- it places `base + line` on the vector output;
- it raises a one-cycle valid strobe.

The host ends service with a non-specific end-of-interrupt command. This releases the highest-priority line in service. A cascade-role input tells the block how to interpret the cascade byte. A vector probe port reports whether a given vector number belongs to this controller.

Top module: `irq8_ctrl_top`

## Requirements
- R1: After reset the interrupt output is low and stays low until an initialisation sequence completes. Command byte 0x11 starts the sequence, clears every in-service bit and holds the interrupt output low. The following three data-port writes are taken, in order, as vector base, cascade byte and mode byte. A 0x11 written partway through the sequence restarts it at the vector base.
- R2: On an accepted acknowledge, `vecOut` shows base + n for the winning line n, and `vecValid` is high in the cycle after the acknowledge edge. Bases of 0x20 and 0x28 give 0x20–0x27 and 0x28–0x2F.
- R3: With `cascadeRole`=1 (primary), `slaveLines` equals the cascade byte and `slaveId` is 0. With `cascadeRole`=0 (secondary), `slaveLines` is 0 and `slaveId` equals cascade byte bits [2:0].
- R4: Mode byte bit 0 set to 1 selects processor-vector mode and enables the interrupt output. With bit 0 at 0, the interrupt output stays low.
- R5: Outside the configuration sequence, a data-port write (`portSel`=1) replaces the 8-bit mask, where bit n set masks line n. A data-port read (`rdEn`=1, `portSel`=1) returns the mask combinationally; otherwise `rdData` is 0. The mask resets to 0xFF and keeps its value across re-initialisation.
- R6: Command byte 0x20 clears the in-service bit of the lowest-numbered line currently in service, and only that bit.
- R7: `probeHit` is 1 exactly when base ≤ `probeVec` < base + 8, compared without 8-bit wrap.
- R8: Line 0 has the highest priority. The lowest-numbered unmasked pending line is presented only if its index is strictly below that of every line in service.
- R9: An acknowledge sets the winning line's in-service bit. An acknowledge while the interrupt output is low changes nothing and produces no `vecValid`.
- R10: Request lines are sampled into a register on each clock. The interrupt output reflects that register from the cycle after a request changes, and stays high while an eligible unmasked request exists.
- R11: A command byte other than 0x11 or 0x20 is ignored. It leaves the configuration sequence, the in-service set and the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe |
| portSel | input | 1 | 0 = command port, 1 = data port |
| wrData | input | 8 | Host write byte |
| rdData | output | 8 | Mask readback on data-port reads, otherwise 0 |
| reqLines | input | 8 | Level-sensitive request lines, bit n = line n |
| ackPulse | input | 1 | Host interrupt acknowledge |
| cascadeRole | input | 1 | 1 = primary, 0 = secondary |
| probeVec | input | 8 | Vector number to test for ownership |
| intOut | output | 1 | Interrupt request to the host |
| vecOut | output | 8 | Vector of the acknowledged line |
| vecValid | output | 1 | One-cycle strobe qualifying vecOut |
| slaveLines | output | 8 | Lines that carry a secondary controller (primary role) |
| slaveId | output | 3 | Identity number (secondary role) |
| probeHit | output | 1 | probeVec lies inside this controller's vector window |

## Verification
The bench targets the same-line case: a request whose line is already in service must not re-raise the interrupt. A design comparing with ≤ instead of < would raise the interrupt again and nest the same line. End-of-interrupt with two lines in service must release only the lower-numbered one. A design that cleared the whole set would let a lower-priority request through early.

Restarting the sequence midway must send the next data byte to the base again. A design that kept counting would load the base into the cascade byte, giving wrong vectors. The mask must come through re-initialisation unchanged; a design that reset it there would unmask every line. The ownership probe is tested at both window edges. An off-by-one there would claim a neighbouring controller's vector.

// File: rtl/irq8_pkg.sv
package irq8_pkg;

  localparam logic [7:0] CMD_INIT = 8'h11;
  localparam logic [7:0] CMD_EOI  = 8'h20;

  typedef enum logic [2:0] {
    ST_UNINIT = 3'd0,
    ST_BASE   = 3'd1,
    ST_CASC   = 3'd2,
    ST_MODE   = 3'd3,
    ST_RUN    = 3'd4
  } seqState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic ldBase;
    logic ldCasc;
    logic ldMode;
    logic ldMask;
    logic eoi;
    logic initClr;
    logic running;
  } ctlStrobe_t;

endpackage

// File: rtl/irq8_ctrl.sv
module irq8_ctrl
  import irq8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] INIT_CMD = DATA_W'(CMD_INIT),
  parameter logic [DATA_W-1:0] EOI_CMD  = DATA_W'(CMD_EOI)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              portSel,
  input  logic [DATA_W-1:0] wrData,
  output ctlStrobe_t        strb
);

  seqState_t stateQ, stateD;
  logic cmdWr, dataWr, isInit, isEoi;

  assign cmdWr  = wrEn && !portSel;
  assign dataWr = wrEn && portSel;
  assign isInit = (wrData == INIT_CMD);
  assign isEoi  = (wrData == EOI_CMD);

  always_comb begin
    stateD       = stateQ;
    strb         = '0;
    strb.running = (stateQ == ST_RUN);
    if (cmdWr) begin
      if (isInit) begin
        strb.initClr = 1'b1;
        stateD       = ST_BASE;
      end else if (isEoi) begin
        strb.eoi = 1'b1;
      end
    end
    if (dataWr) begin
      unique case (stateQ)
        ST_BASE: begin strb.ldBase = 1'b1; stateD = ST_CASC; end
        ST_CASC: begin strb.ldCasc = 1'b1; stateD = ST_MODE; end
        ST_MODE: begin strb.ldMode = 1'b1; stateD = ST_RUN;  end
        default: strb.ldMask = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= ST_UNINIT;
    else        stateQ <= stateD;
  end

  // R1: sequence advances base -> cascade -> mode
  p_seq_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dataWr && stateQ == ST_BASE) |=> (stateQ == ST_CASC));

  p_cas_to_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dataWr && stateQ == ST_CASC) |=> (stateQ == ST_MODE));

  // R1: a restart leaves run state
  p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strb.initClr |=> !strb.running);

  // R11: unknown commands leave the sequence alone
  p_ignore_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdWr && !isInit && !isEoi) |=> $stable(stateQ));

endmodule

// File: rtl/irq8_dpath.sv
module irq8_dpath
  import irq8_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctlStrobe_t           strb,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 rdEn,
  input  logic                 portSel,
  output logic [DATA_W-1:0]    rdData,
  input  logic [NUM_LINES-1:0] reqLines,
  input  logic                 ackPulse,
  input  logic                 cascadeRole,
  input  logic [DATA_W-1:0]    probeVec,
  output logic                 intOut,
  output logic [DATA_W-1:0]    vecOut,
  output logic                 vecValid,
  output logic [NUM_LINES-1:0] slaveLines,
  output logic [IDX_W-1:0]     slaveId,
  output logic                 probeHit
);

  logic [NUM_LINES-1:0] reqQ, isrQ, isrNext, maskQ, pending, eligVec;
  logic [DATA_W-1:0]    baseQ, cascQ;
  logic                 modeQ;
  logic                 pendFound, isrFound, ackTake;
  logic [IDX_W-1:0]     pendIdx, isrIdx;

  assign pending = reqQ & ~maskQ;

  // line gi is eligible if pending and no line at or above its priority is in service
  for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_elig
    assign eligVec[gi] = pending[gi] && !(|isrQ[gi:0]);
  end

  always_comb begin
    pendFound = 1'b0;
    pendIdx   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pending[i]) begin
        pendFound = 1'b1;
        pendIdx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    isrFound = 1'b0;
    isrIdx   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (isrQ[i]) begin
        isrFound = 1'b1;
        isrIdx   = IDX_W'(i);
      end
    end
  end

  assign intOut  = strb.running && modeQ && pendFound && eligVec[pendIdx];
  assign ackTake = ackPulse && intOut;

  always_comb begin
    isrNext = isrQ;
    if (strb.eoi && isrFound) isrNext[isrIdx] = 1'b0;
    if (ackTake)              isrNext[pendIdx] = 1'b1;
    if (strb.initClr)         isrNext = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqQ     <= '0;
      isrQ     <= '0;
      maskQ    <= '1;
      baseQ    <= '0;
      cascQ    <= '0;
      modeQ    <= 1'b0;
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      reqQ     <= reqLines;
      isrQ     <= isrNext;
      if (strb.ldMask) maskQ <= wrData[NUM_LINES-1:0];
      if (strb.ldBase) baseQ <= wrData;
      if (strb.ldCasc) cascQ <= wrData;
      if (strb.ldMode) modeQ <= wrData[0];
      vecValid <= ackTake;
      if (ackTake) vecOut <= baseQ + DATA_W'(pendIdx);
    end
  end

  assign rdData     = (rdEn && portSel) ? DATA_W'(maskQ) : '0;
  assign slaveLines = cascadeRole ? cascQ[NUM_LINES-1:0] : '0;
  assign slaveId    = cascadeRole ? '0 : cascQ[IDX_W-1:0];
  assign probeHit   = ({1'b0, probeVec} >= {1'b0, baseQ}) &&
                      ({1'b0, probeVec} <  ({1'b0, baseQ} + (DATA_W+1)'(NUM_LINES)));

  // R10: interrupt only with some unmasked sampled request
  p_int_has_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    intOut |-> (|(reqQ & ~maskQ)));

  // R9: a vector strobe always follows an acknowledge
  p_vec_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid |-> $past(ackPulse));

  // R6: end-of-interrupt releases exactly one line
  p_eoi_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.eoi && !ackTake && !strb.initClr && (|isrQ))
      |=> ($countones(isrQ) == $countones($past(isrQ)) - 1));

  // R1: initialisation empties the in-service set
  p_init_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strb.initClr |=> (isrQ == '0));

  // R5: mask survives initialisation
  p_mask_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.initClr |=> $stable(maskQ));

endmodule

// File: rtl/irq8_ctrl_top.sv
module irq8_ctrl_top
  import irq8_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_LINES = 8,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic                 portSel,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic [NUM_LINES-1:0] reqLines,
  input  logic                 ackPulse,
  input  logic                 cascadeRole,
  input  logic [DATA_W-1:0]    probeVec,
  output logic                 intOut,
  output logic [DATA_W-1:0]    vecOut,
  output logic                 vecValid,
  output logic [NUM_LINES-1:0] slaveLines,
  output logic [IDX_W-1:0]     slaveId,
  output logic                 probeHit
);

  ctlStrobe_t strb;

  irq8_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrEn    (wrEn),
    .portSel (portSel),
    .wrData  (wrData),
    .strb    (strb)
  );

  irq8_dpath #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) dpath_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .wrData      (wrData),
    .rdEn        (rdEn),
    .portSel     (portSel),
    .rdData      (rdData),
    .reqLines    (reqLines),
    .ackPulse    (ackPulse),
    .cascadeRole (cascadeRole),
    .probeVec    (probeVec),
    .intOut      (intOut),
    .vecOut      (vecOut),
    .vecValid    (vecValid),
    .slaveLines  (slaveLines),
    .slaveId     (slaveId),
    .probeHit    (probeHit)
  );

endmodule

// File: tb/irq8_ctrl_top_tb.sv
`timescale 1ns/1ps
module irq8_ctrl_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0, portSel = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] reqLines = '0;
  logic       ackPulse = 1'b0, cascadeRole = 1'b1;
  logic [7:0] probeVec = '0;
  logic       intOut, vecValid, probeHit;
  logic [7:0] vecOut, slaveLines;
  logic [2:0] slaveId;

  int nChecks = 0, nFails = 0;

  // model state
  logic [7:0] mBase = 8'h00, mCasc = 8'h00, mMask = 8'hFF, mIsr = 8'h00, mIrr = 8'h00;
  logic       mMode = 1'b0;
  int         mSt = 0;

  always #2 clk = ~clk;

  irq8_ctrl_top dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .portSel(portSel),
    .wrData(wrData), .rdData(rdData), .reqLines(reqLines), .ackPulse(ackPulse),
    .cascadeRole(cascadeRole), .probeVec(probeVec), .intOut(intOut),
    .vecOut(vecOut), .vecValid(vecValid), .slaveLines(slaveLines),
    .slaveId(slaveId), .probeHit(probeHit)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lowIdx(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit expInt();
    int c = lowIdx(mIrr & ~mMask);
    int s = lowIdx(mIsr);
    return (mSt == 4) && mMode && (c < 8) && (c < s);
  endfunction

  // one clock: predict, advance, compare
  task automatic cyc();
    bit         preInt = expInt();
    int         c = lowIdx(mIrr & ~mMask);
    bit         eValid = ackPulse && preInt;
    logic [7:0] eVec = mBase + 8'(c);
    bit         initC = 1'b0, eoiC = 1'b0;
    if (wrEn && !portSel) begin
      if (wrData == 8'h11) begin initC = 1'b1; mSt = 1; end
      else if (wrData == 8'h20) eoiC = 1'b1;
    end
    if (wrEn && portSel) begin
      case (mSt)
        1: begin mBase = wrData; mSt = 2; end
        2: begin mCasc = wrData; mSt = 3; end
        3: begin mMode = wrData[0]; mSt = 4; end
        default: mMask = wrData;
      endcase
    end
    if (initC) mIsr = 8'h00;
    else begin
      if (eoiC && lowIdx(mIsr) < 8) mIsr[lowIdx(mIsr)] = 1'b0;
      if (eValid) mIsr[c] = 1'b1;
    end
    mIrr = reqLines;
    @(posedge clk); #1;
    chk(vecValid == eValid, "R9 vecValid", 32'(vecValid), 32'(eValid));
    if (eValid) chk(vecOut == eVec, "R2 vecOut", 32'(vecOut), 32'(eVec));
    chk(intOut == expInt(), "R10/R8 intOut", 32'(intOut), 32'(expInt()));
    chk(rdData == ((rdEn && portSel) ? mMask : 8'h00), "R5 rdData", 32'(rdData),
        32'((rdEn && portSel) ? mMask : 8'h00));
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wrEn = 1'b1; portSel = sel; wrData = d;
    cyc();
    wrEn = 1'b0; portSel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic ack();
    ackPulse = 1'b1; cyc(); ackPulse = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 / R5 reset state
    rdEn = 1'b1; portSel = 1'b1;
    #0;
    chk(intOut == 1'b0, "R1 reset intOut", 32'(intOut), 0);
    chk(rdData == 8'hFF, "R5 reset mask", 32'(rdData), 32'hFF);
    portSel = 1'b0;
    reqLines = 8'h01; idle(2);
    chk(intOut == 1'b0, "R1 uninit intOut", 32'(intOut), 0);

    // R1 init sequence, base 0x20, primary cascade 0x04, mode 0x01
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    cascadeRole = 1'b1; #1;
    chk(slaveLines == 8'h04, "R3 primary slaveLines", 32'(slaveLines), 32'h04);
    chk(slaveId == 3'd0, "R3 primary slaveId", 32'(slaveId), 0);
    cascadeRole = 1'b0; #1;
    chk(slaveLines == 8'h00, "R3 secondary slaveLines", 32'(slaveLines), 0);
    chk(slaveId == 3'd4, "R3 secondary slaveId", 32'(slaveId), 4);
    cascadeRole = 1'b1;

    // R7 ownership edges
    probeVec = 8'h1F; #1; chk(probeHit == 1'b0, "R7 below", 32'(probeHit), 0);
    probeVec = 8'h20; #1; chk(probeHit == 1'b1, "R7 low edge", 32'(probeHit), 1);
    probeVec = 8'h27; #1; chk(probeHit == 1'b1, "R7 high edge", 32'(probeHit), 1);
    probeVec = 8'h28; #1; chk(probeHit == 1'b0, "R7 above", 32'(probeHit), 0);

    // R5 unmask all, read back
    wr(1'b1, 8'h00);
    rdEn = 1'b1; portSel = 1'b1; #1;
    chk(rdData == 8'h00, "R5 mask readback", 32'(rdData), 0);
    rdEn = 1'b0; portSel = 1'b0;

    // R8 / R9 / R2 / R6 nesting
    reqLines = 8'h08; idle(1);
    chk(intOut == 1'b1, "R10 line3 raises", 32'(intOut), 1);
    ack();
    chk(vecOut == 8'h23, "R2 line3 vector", 32'(vecOut), 32'h23);
    chk(intOut == 1'b0, "R8 same line blocked", 32'(intOut), 0);
    reqLines = 8'h28; idle(1);
    chk(intOut == 1'b0, "R8 lower priority blocked", 32'(intOut), 0);
    reqLines = 8'h0A; idle(1);
    chk(intOut == 1'b1, "R8 higher priority nests", 32'(intOut), 1);
    ack();
    chk(vecOut == 8'h21, "R2 line1 vector", 32'(vecOut), 32'h21);
    reqLines = 8'h00; idle(1);
    ack();
    chk(vecValid == 1'b0, "R9 ack ignored when idle", 32'(vecValid), 0);
    reqLines = 8'h04; idle(1);
    chk(intOut == 1'b0, "R6 line2 blocked by line1", 32'(intOut), 0);
    wr(1'b0, 8'h20);
    chk(intOut == 1'b1, "R6 eoi releases only line1", 32'(intOut), 1);

    // R11 ignored command
    wr(1'b0, 8'h55);
    chk(intOut == 1'b1, "R11 unknown cmd no effect", 32'(intOut), 1);
    wr(1'b1, 8'h00);
    rdEn = 1'b1; portSel = 1'b1; #1;
    chk(rdData == 8'h00, "R11 still in mask mode", 32'(rdData), 0);
    rdEn = 1'b0; portSel = 1'b0;

    // R1 restart mid-sequence, new base 0x28; mask kept
    wr(1'b1, 8'h10);
    wr(1'b0, 8'h11); wr(1'b1, 8'h30);
    wr(1'b0, 8'h11); wr(1'b1, 8'h28); wr(1'b1, 8'h02); wr(1'b1, 8'h01);
    rdEn = 1'b1; portSel = 1'b1; #1;
    chk(rdData == 8'h10, "R5 mask survives reinit", 32'(rdData), 32'h10);
    rdEn = 1'b0; portSel = 1'b0;
    reqLines = 8'h01; idle(1); ack();
    chk(vecOut == 8'h28, "R1 restart base", 32'(vecOut), 32'h28);
    reqLines = 8'h80; wr(1'b0, 8'h20); idle(1); ack();
    chk(vecOut == 8'h2F, "R2 top of window", 32'(vecOut), 32'h2F);

    // R4 mode bit 0 clear
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h00);
    reqLines = 8'h01; idle(2);
    chk(intOut == 1'b0, "R4 mode 0 silent", 32'(intOut), 0);
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    wr(1'b1, 8'h00);

    // random traffic
    void'($urandom(32'd2024));
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 99));
      reqLines = 8'($urandom);
      ackPulse = ($urandom_range(0, 99) < 30);
      rdEn     = $urandom_range(0, 1) == 1;
      if (r < 10) begin wrEn = 1'b1; portSel = 1'b0; wrData = 8'h20; end
      else if (r < 14) begin wrEn = 1'b1; portSel = 1'b1; wrData = 8'($urandom) & 8'($urandom); end
      else if (r < 16) begin wrEn = 1'b1; portSel = 1'b0; wrData = 8'($urandom); end
      else begin wrEn = 1'b0; portSel = $urandom_range(0, 1) == 1; end
      cyc();
      wrEn = 1'b0; ackPulse = 1'b0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule